// File: doc/BRIEF.md
# Pulse Feature Extractor

This block watches the sample stream of one digitizer channel for a single recorded event and condenses it into a short feature record: the baseline level, the height and position of the largest excursion above that baseline, the charge collected inside a chosen window, and the leading-edge time. The edge time can be taken either where the pulse first rises through a fixed level above the baseline, or where it rises through a programmed fraction of its own peak height (constant-fraction timing). The record is produced once per event. A downstream packer can send it next to the raw waveform or in place of it.

Samples are written into a local buffer while the peak, charge and baseline sums are gathered in the same pass. After the end-of-record marker, a short second pass reads the buffer back from index 0 up to the peak to locate the threshold crossing. The crossing is then refined by linear interpolation to a fixed-point sub-sample fraction. Samples that arrive while this second pass runs are dropped, which gives a short dead time per record.

Top module: `pulse_feature_extractor`

## Requirements
- R1: The baseline equals the sum of the first 2^`cfgBaseLog2` samples of the record, shifted right by `cfgBaseLog2` (floor average). The record must be at least that long.
- R2: `peakAmp` equals the largest raw sample minus the baseline. `peakIdx` is the index, counted from 0 at the sample marked first, of the earliest sample that holds that maximum.
- R3: `charge` is the signed sum of (sample − baseline) over indices from `cfgWinLo` to `cfgWinHi` inclusive. Window indices beyond the end of the record contribute nothing.
- R4: With `cfgCfdMode`=1, the edge threshold is floor(`peakAmp` × `cfgFraction` / 2^FRAC_W), with `cfgFraction` an unsigned FRAC_W-bit fraction of one.
- R5: With `cfgCfdMode`=0, the edge threshold is the signed value `cfgLevel`, measured relative to the baseline.
- R6: The crossing is the first index i with 1 ≤ i ≤ `peakIdx` where (sample[i−1] − baseline) < threshold ≤ (sample[i] − baseline). If sample[i] − baseline equals the threshold, `edgeIdx`=i and `edgeFrac`=0. Otherwise `edgeIdx`=i−1 and `edgeFrac`=floor((threshold − a)·2^FRAC_W/(b − a)), where a and b are the baseline-subtracted samples at i−1 and i.
- R7: If no index satisfies R6, `edgeBad`=1 and both `edgeIdx` and `edgeFrac` read 0.
- R8: `featValid` is high for exactly one cycle per record, some cycles after the record ends. The outputs are meaningful in that cycle. It is low out of reset.
- R9: A record ends at the sample marked last, or after DEPTH samples, whichever comes first. A single sample marked both first and last forms a one-sample record.
- R10: Samples are ignored from the end of a record until the cycle after `featValid`, even if marked first. Samples not marked first are ignored while no record is open.
- R11: `peakAmp` is never negative in the cycle `featValid` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| sampleValid | input | 1 | Sample present this cycle |
| sampleData | input | SAMPLE_W | Unsigned raw sample |
| sampleFirst | input | 1 | Sample is index 0 of a record |
| sampleLast | input | 1 | Sample closes the record |
| cfgBaseLog2 | input | clog2(clog2(DEPTH)+1) | log2 of baseline sample count |
| cfgWinLo | input | clog2(DEPTH) | First index of charge window |
| cfgWinHi | input | clog2(DEPTH) | Last index of charge window |
| cfgCfdMode | input | 1 | 1 = constant-fraction, 0 = fixed level |
| cfgFraction | input | FRAC_W | Constant-fraction factor |
| cfgLevel | input | SAMPLE_W+1 | Signed fixed level above baseline |
| featValid | output | 1 | Feature record strobe |
| baseline | output | SAMPLE_W | Baseline average |
| peakAmp | output | SAMPLE_W+1 | Signed peak above baseline |
| peakIdx | output | clog2(DEPTH) | Index of peak |
| charge | output | SAMPLE_W+clog2(DEPTH)+2 | Signed windowed charge |
| edgeIdx | output | clog2(DEPTH) | Integer part of edge time |
| edgeFrac | output | FRAC_W | Fractional part of edge time |
| edgeBad | output | 1 | No crossing found |

## Verification
Two cases can land in the same cycle of the second pass. The first is a crossing detection. The second is the end-of-scan condition that fires when the read index reaches the peak. A step waveform whose first sample at the threshold is also the first sample of its flat maximum provokes this overlap, and the bench expects the edge to be reported at the peak index with a zero fraction. At the input side, start-of-record and end-of-record also coincide on a one-sample record, which must close with an invalid edge. Every record is judged against an arithmetic model in the bench, across sweeps of mode, baseline length, pulse position, amplitude, fraction and window.

// File: rtl/pfx_pkg.sv
package pfx_pkg;

  typedef struct packed {
    logic start;   // sample is index 0 of a new record
    logic take;    // sample is accepted this cycle
    logic setup;   // derive baseline, peak, charge, threshold
    logic scan;    // second pass: issue read and evaluate returned sample
  } pfxStrobes_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CAPT,
    ST_SETUP,
    ST_SCAN,
    ST_OUT
  } pfxState_t;

endpackage

// File: rtl/pfx_control.sv
module pfx_control
  import pfx_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        sampleValid,
  input  logic        sampleFirst,
  input  logic        sampleLast,
  input  logic        idxFull,
  input  logic        hit,
  input  logic        scanEnd,
  output pfxStrobes_t st,
  output logic        featValid
);

  pfxState_t state, nxt;

  always_comb begin
    st  = '0;
    nxt = state;
    case (state)
      ST_IDLE: begin
        if (sampleValid && sampleFirst) begin
          st.take  = 1'b1;
          st.start = 1'b1;
          nxt = sampleLast ? ST_SETUP : ST_CAPT;
        end
      end
      ST_CAPT: begin
        if (sampleValid) begin
          st.take  = 1'b1;
          st.start = sampleFirst;
          if (sampleLast || (idxFull && !sampleFirst)) nxt = ST_SETUP;
        end
      end
      ST_SETUP: begin
        st.setup = 1'b1;
        nxt = ST_SCAN;
      end
      ST_SCAN: begin
        st.scan = 1'b1;
        if (hit || scanEnd) nxt = ST_OUT;
      end
      ST_OUT:  nxt = ST_IDLE;
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nxt;
  end

  assign featValid = (state == ST_OUT);

endmodule

// File: rtl/pfx_datapath.sv
module pfx_datapath
  import pfx_pkg::*;
#(
  parameter int SW    = 12,
  parameter int DEPTH = 1024,
  parameter int FW    = 8
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  pfxStrobes_t                   st,
  input  logic [SW-1:0]                 sampleData,
  input  logic [$clog2($clog2(DEPTH)+1)-1:0] cfgBaseLog2,
  input  logic [$clog2(DEPTH)-1:0]      cfgWinLo,
  input  logic [$clog2(DEPTH)-1:0]      cfgWinHi,
  input  logic                          cfgCfdMode,
  input  logic [FW-1:0]                 cfgFraction,
  input  logic signed [SW:0]            cfgLevel,
  output logic                          idxFull,
  output logic                          hit,
  output logic                          scanEnd,
  output logic [SW-1:0]                 baseline,
  output logic signed [SW:0]            peakAmp,
  output logic [$clog2(DEPTH)-1:0]      peakIdx,
  output logic signed [SW+$clog2(DEPTH)+1:0] charge,
  output logic [$clog2(DEPTH)-1:0]      edgeIdx,
  output logic [FW-1:0]                 edgeFrac,
  output logic                          edgeBad
);

  localparam int IW  = $clog2(DEPTH);
  localparam int BSW = SW + IW;        // raw sum over up to DEPTH samples
  localparam int CW  = SW + IW + 2;    // signed charge
  localparam int DW  = SW + 2;         // signed baseline-subtracted sample
  localparam int PW  = SW + 1 + FW;    // peak times fraction
  localparam int QW  = DW + FW;        // interpolation dividend

  // first pass state
  logic [SW-1:0]  mem [DEPTH];
  logic [IW-1:0]  idx, sIdx, maxIdx;
  logic [BSW-1:0] baseSum, rawSum;
  logic [SW-1:0]  rawMax;
  logic [IW:0]    winCnt;
  logic           inBase, inWin;

  assign sIdx    = st.start ? '0 : idx;
  assign idxFull = (idx == IW'(DEPTH - 1));
  assign inBase  = ({1'b0, sIdx} < ((IW+1)'(1) << cfgBaseLog2));
  assign inWin   = (sIdx >= cfgWinLo) && (sIdx <= cfgWinHi);

  // derived values, registered on setup
  logic [SW-1:0]         baseNow;
  logic signed [SW:0]    peakNow;
  logic [CW-1:0]         winBase;
  logic signed [CW-1:0]  chargeNow;
  logic [PW-1:0]         prod;
  logic signed [DW-1:0]  thrNow;

  assign baseNow   = SW'(baseSum >> cfgBaseLog2);
  assign peakNow   = $signed({1'b0, rawMax}) - $signed({1'b0, baseNow});
  assign winBase   = CW'(winCnt) * CW'(baseNow);
  assign chargeNow = $signed(CW'(rawSum) - winBase);
  assign prod      = PW'(peakNow) * PW'(cfgFraction);
  assign thrNow    = cfgCfdMode ? $signed({1'b0, (SW+1)'(prod >> FW)}) : DW'(cfgLevel);

  // second pass state
  logic [SW-1:0]        baseReg, rdData;
  logic signed [SW:0]   peakReg;
  logic signed [CW-1:0] chargeReg;
  logic signed [DW-1:0] thr, prevVal, cur, num, den;
  logic [IW-1:0]        rdIdx, rdPos, edgeIdxR;
  logic [FW-1:0]        edgeFracR;
  logic                 rdValid, havePrev, edgeBadR, evalOn, crossNow;
  logic [QW-1:0]        numSh, denExt;

  assign cur      = $signed({2'b00, rdData}) - $signed({2'b00, baseReg});
  assign evalOn   = st.scan && rdValid;
  assign crossNow = havePrev && (prevVal < thr) && (cur >= thr);
  assign num      = thr - prevVal;
  assign den      = cur - prevVal;
  assign numSh    = {num, {FW{1'b0}}};
  assign denExt   = (den == '0) ? QW'(1) : {{FW{1'b0}}, den};

  always_ff @(posedge clk) begin
    if (st.take) mem[sIdx] <= sampleData;
    rdData <= mem[rdIdx];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      idx       <= '0;
      maxIdx    <= '0;
      baseSum   <= '0;
      rawSum    <= '0;
      rawMax    <= '0;
      winCnt    <= '0;
      baseReg   <= '0;
      peakReg   <= '0;
      chargeReg <= '0;
      thr       <= '0;
      rdIdx     <= '0;
      rdPos     <= '0;
      rdValid   <= 1'b0;
      prevVal   <= '0;
      havePrev  <= 1'b0;
      edgeIdxR  <= '0;
      edgeFracR <= '0;
      edgeBadR  <= 1'b1;
    end else begin
      if (st.take) begin
        idx     <= sIdx + IW'(1);
        baseSum <= (st.start ? '0 : baseSum) + (inBase ? BSW'(sampleData) : '0);
        rawSum  <= (st.start ? '0 : rawSum)  + (inWin  ? BSW'(sampleData) : '0);
        winCnt  <= (st.start ? '0 : winCnt)  + (inWin  ? (IW+1)'(1) : '0);
        if (st.start || (sampleData > rawMax)) begin
          rawMax <= sampleData;
          maxIdx <= sIdx;
        end
      end
      if (st.setup) begin
        baseReg   <= baseNow;
        peakReg   <= peakNow;
        chargeReg <= chargeNow;
        thr       <= thrNow;
        rdIdx     <= '0;
        havePrev  <= 1'b0;
        edgeBadR  <= 1'b1;
        edgeIdxR  <= '0;
        edgeFracR <= '0;
      end else if (st.scan) begin
        rdIdx <= rdIdx + IW'(1);
      end
      rdValid <= st.scan;
      rdPos   <= rdIdx;
      if (evalOn) begin
        prevVal  <= cur;
        havePrev <= 1'b1;
        if (crossNow) begin
          edgeBadR <= 1'b0;
          if (cur == thr) begin
            edgeIdxR  <= rdPos;
            edgeFracR <= '0;
          end else begin
            edgeIdxR  <= rdPos - IW'(1);
            edgeFracR <= FW'(numSh / denExt);
          end
        end
      end
    end
  end

  assign hit      = evalOn && crossNow;
  assign scanEnd  = evalOn && (rdPos == maxIdx);
  assign baseline = baseReg;
  assign peakAmp  = peakReg;
  assign peakIdx  = maxIdx;
  assign charge   = chargeReg;
  assign edgeIdx  = edgeIdxR;
  assign edgeFrac = edgeFracR;
  assign edgeBad  = edgeBadR;

endmodule

// File: rtl/pulse_feature_extractor.sv
module pulse_feature_extractor
  import pfx_pkg::*;
#(
  parameter int SAMPLE_W = 12,
  parameter int DEPTH    = 1024,
  parameter int FRAC_W   = 8
) (
  input  logic                                   clk,
  input  logic                                   rstN,
  input  logic                                   sampleValid,
  input  logic [SAMPLE_W-1:0]                    sampleData,
  input  logic                                   sampleFirst,
  input  logic                                   sampleLast,
  input  logic [$clog2($clog2(DEPTH)+1)-1:0]     cfgBaseLog2,
  input  logic [$clog2(DEPTH)-1:0]               cfgWinLo,
  input  logic [$clog2(DEPTH)-1:0]               cfgWinHi,
  input  logic                                   cfgCfdMode,
  input  logic [FRAC_W-1:0]                      cfgFraction,
  input  logic signed [SAMPLE_W:0]               cfgLevel,
  output logic                                   featValid,
  output logic [SAMPLE_W-1:0]                    baseline,
  output logic signed [SAMPLE_W:0]               peakAmp,
  output logic [$clog2(DEPTH)-1:0]               peakIdx,
  output logic signed [SAMPLE_W+$clog2(DEPTH)+1:0] charge,
  output logic [$clog2(DEPTH)-1:0]               edgeIdx,
  output logic [FRAC_W-1:0]                      edgeFrac,
  output logic                                   edgeBad
);

  pfxStrobes_t st;
  logic idxFull, hit, scanEnd;

  pfx_control u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .sampleValid (sampleValid),
    .sampleFirst (sampleFirst),
    .sampleLast  (sampleLast),
    .idxFull     (idxFull),
    .hit         (hit),
    .scanEnd     (scanEnd),
    .st          (st),
    .featValid   (featValid)
  );

  pfx_datapath #(
    .SW    (SAMPLE_W),
    .DEPTH (DEPTH),
    .FW    (FRAC_W)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .st          (st),
    .sampleData  (sampleData),
    .cfgBaseLog2 (cfgBaseLog2),
    .cfgWinLo    (cfgWinLo),
    .cfgWinHi    (cfgWinHi),
    .cfgCfdMode  (cfgCfdMode),
    .cfgFraction (cfgFraction),
    .cfgLevel    (cfgLevel),
    .idxFull     (idxFull),
    .hit         (hit),
    .scanEnd     (scanEnd),
    .baseline    (baseline),
    .peakAmp     (peakAmp),
    .peakIdx     (peakIdx),
    .charge      (charge),
    .edgeIdx     (edgeIdx),
    .edgeFrac    (edgeFrac),
    .edgeBad     (edgeBad)
  );

endmodule

// File: rtl/pfx_checker.sv
module pfx_checker #(
  parameter int SW = 12,
  parameter int IW = 10,
  parameter int FW = 8
) (
  input logic               clk,
  input logic               rstN,
  input logic               featValid,
  input logic               edgeBad,
  input logic [IW-1:0]      edgeIdx,
  input logic [IW-1:0]      peakIdx,
  input logic [FW-1:0]      edgeFrac,
  input logic signed [SW:0] peakAmp
);

  // R8
  pulse_once_chk: assert property (@(posedge clk) disable iff (!rstN)
    featValid |=> !featValid);

  // R7
  bad_edge_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (featValid && edgeBad) |-> (edgeIdx == '0 && edgeFrac == '0));

  // R6
  edge_before_peak_chk: assert property (@(posedge clk) disable iff (!rstN)
    (featValid && !edgeBad) |-> (edgeIdx <= peakIdx));

  // R6
  edge_at_peak_chk: assert property (@(posedge clk) disable iff (!rstN)
    (featValid && !edgeBad && edgeIdx == peakIdx) |-> (edgeFrac == '0));

  // R11
  peak_sign_chk: assert property (@(posedge clk) disable iff (!rstN)
    featValid |-> !peakAmp[SW]);

endmodule

bind pulse_feature_extractor pfx_checker #(
  .SW (SAMPLE_W),
  .IW ($clog2(DEPTH)),
  .FW (FRAC_W)
) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .featValid (featValid),
  .edgeBad   (edgeBad),
  .edgeIdx   (edgeIdx),
  .peakIdx   (peakIdx),
  .edgeFrac  (edgeFrac),
  .peakAmp   (peakAmp)
);

// File: tb/pulse_feature_extractor_test.sv
`timescale 1ns/1ps
module pulse_feature_extractor_test;
  localparam int SW = 12, DEPTH = 64, FW = 8;
  localparam int IW = 6, LW = 3, CW = SW + IW + 2;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic               rstN, sampleValid, sampleFirst, sampleLast, cfgCfdMode;
  logic [SW-1:0]      sampleData;
  logic [LW-1:0]      cfgBaseLog2;
  logic [IW-1:0]      cfgWinLo, cfgWinHi, peakIdx, edgeIdx;
  logic [FW-1:0]      cfgFraction, edgeFrac;
  logic signed [SW:0] cfgLevel, peakAmp;
  logic               featValid, edgeBad;
  logic [SW-1:0]      baseline;
  logic signed [CW-1:0] charge;

  pulse_feature_extractor #(.SAMPLE_W(SW), .DEPTH(DEPTH), .FRAC_W(FW)) uut (
    .clk(clk), .rstN(rstN), .sampleValid(sampleValid), .sampleData(sampleData),
    .sampleFirst(sampleFirst), .sampleLast(sampleLast), .cfgBaseLog2(cfgBaseLog2),
    .cfgWinLo(cfgWinLo), .cfgWinHi(cfgWinHi), .cfgCfdMode(cfgCfdMode),
    .cfgFraction(cfgFraction), .cfgLevel(cfgLevel), .featValid(featValid),
    .baseline(baseline), .peakAmp(peakAmp), .peakIdx(peakIdx), .charge(charge),
    .edgeIdx(edgeIdx), .edgeFrac(edgeFrac), .edgeBad(edgeBad));

  int checks = 0, fails = 0;
  int wave [DEPTH];
  int wlen;
  int eBase, ePeak, eIdx, eCharge, eEdge, eFrac, eBad;

  task automatic check(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic makeWave(int len, int p, int amp, int w, int seed);
    wlen = len;
    for (int i = 0; i < DEPTH; i++) begin
      int v, d;
      v = 300 + ((i * 7 + seed) % 9);
      d = (i > p) ? i - p : p - i;
      if (d < w) v += amp * (w - d) / w;
      if (v > 4095) v = 4095;
      wave[i] = v;
    end
  endtask

  task automatic model();
    int n, sum, mx, thr, a, b;
    n = 1 << cfgBaseLog2;
    sum = 0;
    for (int i = 0; i < n && i < wlen; i++) sum += wave[i];
    eBase = sum >> cfgBaseLog2;
    mx = -1; eIdx = 0;
    for (int i = 0; i < wlen; i++) if (wave[i] > mx) begin mx = wave[i]; eIdx = i; end
    ePeak = mx - eBase;
    eCharge = 0;
    for (int i = 0; i < wlen; i++)
      if (i >= int'(cfgWinLo) && i <= int'(cfgWinHi)) eCharge += wave[i] - eBase;
    thr = cfgCfdMode ? ((ePeak * int'(cfgFraction)) >>> FW) : int'(cfgLevel);
    eBad = 1; eEdge = 0; eFrac = 0;
    for (int i = 1; i <= eIdx; i++) begin
      a = wave[i-1] - eBase;
      b = wave[i] - eBase;
      if (eBad == 1 && a < thr && b >= thr) begin
        eBad = 0;
        if (b == thr) begin eEdge = i; eFrac = 0; end
        else begin eEdge = i - 1; eFrac = ((thr - a) * (1 << FW)) / (b - a); end
      end
    end
  endtask

  task automatic collect(string tag, bit junk);
    int n;
    n = 0;
    while (1) begin
      @(negedge clk);
      if (featValid || n >= 3000) break;
      if (junk && n < 3) begin
        sampleValid = 1; sampleFirst = 1; sampleLast = (n == 2); sampleData = SW'(4000 - n);
      end else begin
        sampleValid = 0; sampleFirst = 0; sampleLast = 0;
      end
      n++;
    end
    sampleValid = 0; sampleFirst = 0; sampleLast = 0;
    check("R8", {tag, " strobe seen"}, int'(featValid), 1);
    model();
    check("R1", {tag, " baseline"}, int'(baseline), eBase);
    check("R2", {tag, " peak amplitude"}, int'(peakAmp), ePeak);
    check("R2", {tag, " peak index"}, int'(peakIdx), eIdx);
    check("R3", {tag, " charge"}, int'(charge), eCharge);
    check("R11", {tag, " peak sign"}, int'(peakAmp >= 0), 1);
    if (eBad == 1) begin
      check("R7", {tag, " edge flag"}, int'(edgeBad), 1);
      check("R7", {tag, " edge index zero"}, int'(edgeIdx), 0);
      check("R7", {tag, " edge fraction zero"}, int'(edgeFrac), 0);
    end else begin
      check(cfgCfdMode ? "R4" : "R5", {tag, " edge flag"}, int'(edgeBad), 0);
      check("R6", {tag, " edge index"}, int'(edgeIdx), eEdge);
      check("R6", {tag, " edge fraction"}, int'(edgeFrac), eFrac);
    end
    @(negedge clk);
    check("R8", {tag, " strobe single cycle"}, int'(featValid), 0);
  endtask

  task automatic sendRecord(bit useLast, bit gaps);
    for (int i = 0; i < wlen; i++) begin
      @(negedge clk);
      if (gaps && (i % 3 == 1)) begin
        sampleValid = 0; sampleFirst = 0; sampleLast = 0;
        @(negedge clk);
      end
      sampleValid = 1;
      sampleData  = SW'(wave[i]);
      sampleFirst = (i == 0);
      sampleLast  = useLast && (i == wlen - 1);
    end
  endtask

  task automatic idleNoise();
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      sampleValid = 1; sampleFirst = 0; sampleLast = (i == 3); sampleData = 12'hFFF;
    end
    @(negedge clk);
    sampleValid = 0; sampleLast = 0;
  endtask

  initial begin
    repeat (180000) @(posedge clk);
    fails++; checks++;
    $display("FAIL R8 watchdog: actual hung expected finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    rstN = 0; sampleValid = 0; sampleFirst = 0; sampleLast = 0; sampleData = '0;
    cfgBaseLog2 = 2; cfgWinLo = 0; cfgWinHi = 63; cfgCfdMode = 1;
    cfgFraction = 128; cfgLevel = 100;
    repeat (4) @(negedge clk);
    check("R8", "reset strobe low", int'(featValid), 0);
    rstN = 1;
    @(negedge clk);
    check("R8", "strobe low after reset", int'(featValid), 0);

    // sweep: mode x baseline length x position x amplitude
    for (int m = 0; m < 2; m++)
      for (int k = 0; k < 3; k++)
        for (int pi = 0; pi < 4; pi++)
          for (int ai = 0; ai < 2; ai++) begin
            int p, amp;
            p   = (pi == 0) ? 20 : (pi == 1) ? 26 : (pi == 2) ? 37 : 58;
            amp = ai ? 1500 : 60;
            cfgCfdMode  = m[0];
            cfgBaseLog2 = LW'(k * 2);
            cfgFraction = FW'(64 + 60 * k);
            cfgLevel    = (SW+1)'(amp / 2);
            cfgWinLo    = IW'(p - 4);
            cfgWinHi    = IW'((p + 6 > 63) ? 63 : p + 6);
            makeWave(64, p, amp, 5 + k, m * 13 + pi * 3 + ai);
            sendRecord(1, pi == 1);
            collect("sweep", 0);
          end

    // R4: fraction sweep in constant-fraction mode
    cfgCfdMode = 1; cfgBaseLog2 = 3; cfgWinLo = 20; cfgWinHi = 40;
    for (int f = 0; f < 5; f++) begin
      cfgFraction = (f == 0) ? 8'd1 : (f == 1) ? 8'd77 : (f == 2) ? 8'd128 : (f == 3) ? 8'd200 : 8'd255;
      makeWave(50, 30, 1000, 7, f);
      sendRecord(1, 0);
      collect("R4 fraction", 0);
    end

    // R5: negative fixed level
    cfgCfdMode = 0; cfgLevel = -13'sd3; cfgBaseLog2 = 2;
    makeWave(40, 25, 400, 6, 4);
    sendRecord(1, 0);
    collect("R5 negative level", 0);

    // R7: fixed level above the peak
    cfgLevel = 13'sd3000;
    makeWave(40, 25, 500, 6, 1);
    sendRecord(1, 0);
    collect("R7 no crossing", 0);

    // R6: crossing exactly at the peak sample, hit and scan end together
    cfgLevel = 13'sd150; cfgBaseLog2 = 2; cfgWinLo = 0; cfgWinHi = 63;
    wlen = 30;
    for (int i = 0; i < DEPTH; i++) wave[i] = (i < 10) ? 200 : 350;
    sendRecord(1, 0);
    collect("R6 coincident", 0);
    check("R6", "coincident edge index", int'(edgeIdx), 10);

    // R9: one-sample record
    cfgBaseLog2 = 0; cfgCfdMode = 1;
    makeWave(1, 0, 0, 1, 2);
    sendRecord(1, 0);
    collect("R9 single sample", 0);

    // R9: record closed by depth, no last marker
    cfgBaseLog2 = 4; cfgWinLo = 10; cfgWinHi = 63;
    makeWave(64, 45, 900, 6, 5);
    sendRecord(0, 0);
    collect("R9 full depth", 0);

    // R3: window extends past a short record
    cfgWinLo = 15; cfgWinHi = 63;
    makeWave(25, 18, 700, 4, 6);
    sendRecord(1, 0);
    collect("R3 short record", 0);

    // R10: new record markers during processing, then strays while idle
    cfgWinLo = 0; cfgWinHi = 40; cfgBaseLog2 = 2;
    makeWave(45, 30, 800, 5, 7);
    sendRecord(1, 0);
    collect("R10 busy junk", 1);
    idleNoise();
    makeWave(45, 12, 600, 4, 8);
    sendRecord(1, 0);
    collect("R10 after strays", 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule